// File: doc/BRIEF.md
# Flash Controller Interrupt and Status Register Unit

This unit holds the software-visible interrupt and status state of a memory-mapped flash controller. It keeps five registers: the command register, two configuration words, the controller status word and the interrupt status word. A host writes and reads them through a simple select/strobe register port. It also decides whether a newly written command is accepted. Accepted commands that are recognised are handed to a command engine with a one-cycle start pulse.

The command engine reports back on three event lanes, one for each operation class (load, program, erase). Each lane has a completion strobe and a failure flag. Completions raise class bits and the global pending flag in the interrupt status word. Failures raise error bits in the status word. Software acknowledges by writing a mask to the interrupt status word. The error bits are released only when that acknowledge drops the pending flag. The interrupt output level is the pending flag combined with a polarity bit held in configuration word 1.

Top module: `flash_evt_regs`

## Requirements
- R1: After cold reset the registers read: command 0x0000, configuration 1 0x40C0, configuration 2 0x0000, status 0x0000, interrupt status 0x8080. In the same state irq_o=1 and rdy_o=1. The register select codes are 0 command, 1 configuration 1, 2 configuration 2, 3 status, 4 interrupt status; codes 5 to 7 read 0 and writes to them change nothing.
- R2: A write to the command register while interrupt status bit 15 is 1 is ignored: the command register keeps its value and no start pulse is issued.
- R3: An accepted write of a recognised code stores the code. cmd_go is then high for exactly the following cycle, with cmd_code equal to the code. The recognised codes are 0x0000, 0x0013, 0x001A, 0x001B, 0x0023, 0x0027, 0x002A, 0x002C, 0x0030, 0x0065, 0x0071, 0x0080, 0x0094, 0x0095 and 0x00B0.
- R4: An accepted write of any code that is neither recognised nor a reset code stores the code, sets status bit 10 and interrupt status bit 15, and issues no start pulse.
- R5: An accepted write of 0x00F0 or 0x00F3 performs a warm reset with no start pulse. Every register returns to its R1 value, except interrupt status, which becomes 0x8010.
- R6: A completion on lane 0 (load), lane 1 (program) or lane 2 (erase) sets interrupt status bit 7, 6 or 5 respectively, together with bit 15. If its failure flag is high, it also sets status bit 13, 12 or 11 respectively, together with bit 10. Lanes combine when they fire together.
- R7: A write to interrupt status replaces it with (old AND written value). If bit 15 of that result is 0, status bits 13 to 10 are cleared.
- R8: Events arriving in the same cycle as an interrupt status write are ORed in after the AND-clear. Their error bits survive even when the acknowledge clears the old error bits.
- R9: irq_o equals interrupt status bit 15 XOR NOT configuration 1 bit 6. It is registered, and is valid in the same cycle as the register values it follows.
- R10: Configuration 1 reads back with bits 4 to 0 forced to 0, and rdy_o equals its stored bit 7.
- R11: Configuration 2 is read/write over all 16 bits. The status register is read-only from the host.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low cold reset |
| reg_sel | input | 3 | Register select for reads and writes |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| evt_done | input | 3 | Completion strobes: bit 0 load, bit 1 program, bit 2 erase |
| evt_fail | input | 3 | Failure flags qualifying evt_done |
| cmd_go | output | 1 | One-cycle start pulse for an accepted recognised command |
| cmd_code | output | 16 | Current command register value |
| irq_o | output | 1 | Interrupt output |
| rdy_o | output | 1 | Ready output, configuration 1 bit 7 |

## Verification
The hardest situation to reach is an engine event landing in the same clock as an acknowledge that clears the pending flag. In that cycle the old error bits must go while the new ones stay. The bench first leaves an unacknowledged failure in place, then drives the interrupt-status write and a different failing lane on the same clock edge. A sweep over every low command byte, each with a different configuration pattern, covers acceptance, unknown-code errors, both warm-reset codes and the interrupt polarity.

// File: rtl/flash_evt_pkg.sv
package flash_evt_pkg;
  localparam int DW = 16;
  localparam int NCLS = 3;

  localparam logic [DW-1:0] INT_COLD  = 16'h8080;
  localparam logic [DW-1:0] INT_WARM  = 16'h8010;
  localparam logic [DW-1:0] CFG1_INIT = 16'h40C0;
  localparam logic [DW-1:0] CFG1_RMSK = 16'hFFE0;
  localparam logic [DW-1:0] ERR_MSK   = 16'h3C00;

  localparam int PEND_B   = 15;
  localparam int CMDERR_B = 10;
  localparam int POL_B    = 6;
  localparam int RDY_B    = 7;

  typedef enum logic [2:0] {
    SEL_CMD  = 3'd0,
    SEL_CFG1 = 3'd1,
    SEL_CFG2 = 3'd2,
    SEL_STAT = 3'd3,
    SEL_INT  = 3'd4
  } sel_e;

  // class 0 load, 1 program, 2 erase
  function automatic int done_bit(input int cls);
    return 7 - cls;
  endfunction

  function automatic int err_bit(input int cls);
    return 13 - cls;
  endfunction

  function automatic logic is_reset_cmd(input logic [DW-1:0] c);
    return (c == 16'h00F0) || (c == 16'h00F3);
  endfunction

  function automatic logic is_known_cmd(input logic [DW-1:0] c);
    case (c)
      16'h0000, 16'h0013, 16'h001A, 16'h001B, 16'h0023,
      16'h0027, 16'h002A, 16'h002C, 16'h0030, 16'h0065,
      16'h0071, 16'h0080, 16'h0094, 16'h0095, 16'h00B0: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic irq_level(input logic [DW-1:0] ist,
                                     input logic [DW-1:0] c1);
    return ist[PEND_B] ^ ~c1[POL_B];
  endfunction
endpackage

// File: rtl/fe_cmd_gate.sv
module fe_cmd_gate
  import flash_evt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_cmd,
  input  logic [DW-1:0] wdata,
  input  logic          pending,
  output logic          warm_o,
  output logic          bad_o,
  output logic [DW-1:0] cmd_q,
  output logic          go_q
);
  logic accept, start;

  assign accept = wr_cmd && !pending;
  assign warm_o = accept && is_reset_cmd(wdata);
  assign bad_o  = accept && !is_reset_cmd(wdata) && !is_known_cmd(wdata);
  assign start  = accept && is_known_cmd(wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      go_q  <= 1'b0;
    end else begin
      go_q <= start;
      if (warm_o)      cmd_q <= '0;
      else if (accept) cmd_q <= wdata;
    end
  end
endmodule

// File: rtl/fe_int_bank.sv
module fe_int_bank
  import flash_evt_pkg::*;
#(
  parameter int N_CLS = NCLS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             warm,
  input  logic             bad,
  input  logic             wr_int,
  input  logic [DW-1:0]    wdata,
  input  logic [N_CLS-1:0] done,
  input  logic [N_CLS-1:0] fail,
  output logic [DW-1:0]    int_q,
  output logic [DW-1:0]    stat_q,
  output logic [DW-1:0]    int_nxt
);
  logic [DW-1:0] ev_int, ev_err, acked, stat_base, stat_nxt;

  always_comb begin
    ev_int = '0;
    ev_err = '0;
    for (int i = 0; i < N_CLS; i++) begin
      if (done[i]) begin
        ev_int = ev_int | (16'h1 << PEND_B) | (16'h1 << done_bit(i));
        if (fail[i])
          ev_err = ev_err | (16'h1 << CMDERR_B) | (16'h1 << err_bit(i));
      end
    end
    if (bad) begin
      ev_int = ev_int | (16'h1 << PEND_B);
      ev_err = ev_err | (16'h1 << CMDERR_B);
    end
    acked     = wr_int ? (int_q & wdata) : int_q;
    stat_base = acked[PEND_B] ? stat_q : (stat_q & ~ERR_MSK);
    int_nxt   = warm ? INT_WARM : (acked | ev_int);
    stat_nxt  = warm ? '0 : (stat_base | ev_err);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q  <= INT_COLD;
      stat_q <= '0;
    end else begin
      int_q  <= int_nxt;
      stat_q <= stat_nxt;
    end
  end
endmodule

// File: rtl/fe_cfg_bank.sv
module fe_cfg_bank
  import flash_evt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          warm,
  input  logic          wr_c1,
  input  logic          wr_c2,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] cfg1_q,
  output logic [DW-1:0] cfg2_q,
  output logic [DW-1:0] cfg1_nxt
);
  always_comb begin
    if (warm)       cfg1_nxt = CFG1_INIT;
    else if (wr_c1) cfg1_nxt = wdata;
    else            cfg1_nxt = cfg1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg1_q <= CFG1_INIT;
      cfg2_q <= '0;
    end else begin
      cfg1_q <= cfg1_nxt;
      if (warm)       cfg2_q <= '0;
      else if (wr_c2) cfg2_q <= wdata;
    end
  end
endmodule

// File: rtl/flash_evt_regs.sv
module flash_evt_regs
  import flash_evt_pkg::*;
#(
  parameter int SEL_W = 3,
  parameter int N_CLS = NCLS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic             reg_wr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic [N_CLS-1:0] evt_done,
  input  logic [N_CLS-1:0] evt_fail,
  output logic             cmd_go,
  output logic [DW-1:0]    cmd_code,
  output logic             irq_o,
  output logic             rdy_o
);
  logic wr_cmd, wr_c1, wr_c2, wr_int;
  logic warm, bad, irq_q;
  logic [DW-1:0] cmd_q, cfg1_q, cfg2_q, int_q, stat_q, int_nxt, cfg1_nxt;

  assign wr_cmd = reg_wr && (reg_sel == SEL_W'(SEL_CMD));
  assign wr_c1  = reg_wr && (reg_sel == SEL_W'(SEL_CFG1));
  assign wr_c2  = reg_wr && (reg_sel == SEL_W'(SEL_CFG2));
  assign wr_int = reg_wr && (reg_sel == SEL_W'(SEL_INT));

  fe_cmd_gate u_gate (
    .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .wdata(reg_wdata),
    .pending(int_q[PEND_B]), .warm_o(warm), .bad_o(bad),
    .cmd_q(cmd_q), .go_q(cmd_go)
  );

  fe_int_bank #(.N_CLS(N_CLS)) u_int (
    .clk(clk), .rst_n(rst_n), .warm(warm), .bad(bad), .wr_int(wr_int),
    .wdata(reg_wdata), .done(evt_done), .fail(evt_fail),
    .int_q(int_q), .stat_q(stat_q), .int_nxt(int_nxt)
  );

  fe_cfg_bank u_cfg (
    .clk(clk), .rst_n(rst_n), .warm(warm), .wr_c1(wr_c1), .wr_c2(wr_c2),
    .wdata(reg_wdata), .cfg1_q(cfg1_q), .cfg2_q(cfg2_q), .cfg1_nxt(cfg1_nxt)
  );

  // registered from next-state so it lines up with the register values
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= irq_level(INT_COLD, CFG1_INIT);
    else        irq_q <= irq_level(int_nxt, cfg1_nxt);
  end

  always_comb begin
    case (reg_sel)
      SEL_W'(SEL_CMD):  reg_rdata = cmd_q;
      SEL_W'(SEL_CFG1): reg_rdata = cfg1_q & CFG1_RMSK;
      SEL_W'(SEL_CFG2): reg_rdata = cfg2_q;
      SEL_W'(SEL_STAT): reg_rdata = stat_q;
      SEL_W'(SEL_INT):  reg_rdata = int_q;
      default:          reg_rdata = '0;
    endcase
  end

  assign cmd_code = cmd_q;
  assign irq_o    = irq_q;
  assign rdy_o    = cfg1_q[RDY_B];
endmodule

// File: rtl/flash_evt_regs_chk.sv
module flash_evt_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_cmd,
  input logic        wr_int,
  input logic [15:0] wdata,
  input logic [2:0]  evt_done,
  input logic [2:0]  sel,
  input logic [15:0] rdata,
  input logic [15:0] int_q,
  input logic [15:0] stat_q,
  input logic [15:0] cfg1_q,
  input logic [15:0] cmd_q,
  input logic        go,
  input logic        irq
);
  // R9
  a_r9_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (int_q[15] ^ ~cfg1_q[6]));

  // R2
  a_r2_cmd_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && int_q[15]) |=> ($stable(cmd_q) && !go));

  // R3
  a_r3_go_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> $past(wr_cmd && !int_q[15]));

  // R5
  a_r5_warm_value: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && !int_q[15] && (wdata == 16'h00F0 || wdata == 16'h00F3))
      |=> (int_q == 16'h8010 && cmd_q == 16'h0000 && !go));

  // R7
  a_r7_ack_clears_err: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_int && !wdata[15] && evt_done == 3'b000) |=> ((stat_q & 16'h3C00) == 16'h0000));

  // R6 / R7: an error never stands without the pending flag
  a_r6_err_implies_pend: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & 16'h3C00) != 16'h0000) |-> int_q[15]);

  // R10
  a_r10_cfg1_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'd1) |-> (rdata[4:0] == 5'd0));
endmodule

bind flash_evt_regs flash_evt_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .wr_int(wr_int),
  .wdata(reg_wdata), .evt_done(evt_done), .sel(reg_sel), .rdata(reg_rdata),
  .int_q(int_q), .stat_q(stat_q), .cfg1_q(cfg1_q), .cmd_q(cmd_q),
  .go(cmd_go), .irq(irq_o)
);

// File: tb/flash_evt_regs_tb.sv
module flash_evt_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic [2:0]  evt_done = 3'b0;
  logic [2:0]  evt_fail = 3'b0;
  logic        cmd_go;
  logic [15:0] cmd_code;
  logic        irq_o, rdy_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] m_cmd, m_c1, m_c2, m_st, m_int;
  logic        m_go;

  always #4 clk = ~clk;

  flash_evt_regs u_dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_done(evt_done),
    .evt_fail(evt_fail), .cmd_go(cmd_go), .cmd_code(cmd_code),
    .irq_o(irq_o), .rdy_o(rdy_o)
  );

  function automatic bit recog(input logic [15:0] c);
    logic [15:0] lst [15] = '{16'h00B0, 16'h0095, 16'h0094, 16'h0080, 16'h0071,
                              16'h0065, 16'h0030, 16'h002C, 16'h002A, 16'h0027,
                              16'h0023, 16'h001B, 16'h001A, 16'h0013, 16'h0000};
    for (int k = 0; k < 15; k++) if (lst[k] == c) return 1'b1;
    return 1'b0;
  endfunction

  task automatic model_warm();
    m_cmd = 16'h0; m_c1 = 16'h40C0; m_c2 = 16'h0; m_st = 16'h0; m_int = 16'h8010;
  endtask

  task automatic expect_eq(input string tag, input string what,
                           input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] s, input logic [15:0] exp, input string tag);
    reg_sel = s;
    #1;
    expect_eq(tag, $sformatf("read sel %0d", s), reg_rdata, exp);
  endtask

  task automatic chk_all(input string tag);
    rd(3'd0, m_cmd, tag);
    rd(3'd1, m_c1 & 16'hFFE0, tag);
    rd(3'd2, m_c2, tag);
    rd(3'd3, m_st, tag);
    rd(3'd4, m_int, tag);
    expect_eq("R9", "irq_o", {15'd0, irq_o}, {15'd0, m_int[15] ^ ~m_c1[6]});
    expect_eq("R10", "rdy_o", {15'd0, rdy_o}, {15'd0, m_c1[7]});
  endtask

  // one bus cycle with optional events; model applies ack then ORs events
  task automatic cyc(input bit w, input logic [2:0] s, input logic [15:0] d,
                     input logic [2:0] dn, input logic [2:0] fl);
    @(negedge clk);
    reg_wr = w; reg_sel = s; reg_wdata = d; evt_done = dn; evt_fail = fl;
    m_go = 1'b0;
    if (w) begin
      case (s)
        3'd0: if (!m_int[15]) begin
          if (d == 16'h00F0 || d == 16'h00F3) model_warm();
          else if (recog(d)) begin m_cmd = d; m_go = 1'b1; end
          else begin m_cmd = d; m_st = m_st | 16'h0400; m_int = m_int | 16'h8000; end
        end
        3'd1: m_c1 = d;
        3'd2: m_c2 = d;
        3'd4: begin
          m_int = m_int & d;
          if (!m_int[15]) m_st = m_st & ~16'h3C00;
        end
        default: ;
      endcase
    end
    for (int i = 0; i < 3; i++) begin
      if (dn[i]) begin
        m_int[15] = 1'b1; m_int[7 - i] = 1'b1;
        if (fl[i]) begin m_st[10] = 1'b1; m_st[13 - i] = 1'b1; end
      end
    end
    @(negedge clk);
    reg_wr = 1'b0; evt_done = 3'b0; evt_fail = 3'b0;
    expect_eq("R3", "cmd_go", {15'd0, cmd_go}, {15'd0, m_go});
    if (m_go) expect_eq("R3", "cmd_code", cmd_code, m_cmd);
  endtask

  task automatic wr(input logic [2:0] s, input logic [15:0] d);
    cyc(1'b1, s, d, 3'b0, 3'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    m_cmd = 0; m_c1 = 16'h40C0; m_c2 = 0; m_st = 0; m_int = 16'h8080; m_go = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 cold reset values
    chk_all("R1");
    expect_eq("R1", "irq_o", {15'd0, irq_o}, 16'd1);

    // R2: pending after reset blocks commands
    wr(3'd0, 16'h0080);
    chk_all("R2");
    wr(3'd0, 16'h00F0);
    chk_all("R2");

    // R7: partial ack keeps pending, full ack drops it
    wr(3'd4, 16'h8000);
    chk_all("R7");
    wr(3'd4, 16'h0000);
    chk_all("R7");

    // R11 / R1: cfg2 rw, status and unused selects ignore writes
    wr(3'd2, 16'hA5C3);
    wr(3'd3, 16'hFFFF);
    wr(3'd5, 16'hFFFF);
    chk_all("R11");
    rd(3'd5, 16'h0000, "R1");
    rd(3'd7, 16'h0000, "R1");

    // R3 R4 R5 R9 R10: sweep all low command bytes with varied cfg1
    for (int c = 0; c < 256; c++) begin
      wr(3'd4, 16'h0000);
      wr(3'd1, {c[7:0], ~c[7:0]});
      wr(3'd2, {8'h5A, c[7:0]});
      wr(3'd0, c[15:0]);
      chk_all(recog(c[15:0]) ? "R3" :
              ((c == 16'hF0 || c == 16'hF3) ? "R5" : "R4"));
    end
    wr(3'd4, 16'h0000);
    wr(3'd0, 16'h0100);
    chk_all("R4");

    // R6: each lane with and without failure
    for (int cl = 0; cl < 3; cl++) begin
      for (int f = 0; f < 2; f++) begin
        wr(3'd4, 16'h0000);
        cyc(1'b0, 3'd0, 16'h0, 3'(1 << cl), f ? 3'(1 << cl) : 3'b0);
        chk_all("R6");
      end
    end
    wr(3'd4, 16'h0000);
    cyc(1'b0, 3'd0, 16'h0, 3'b111, 3'b101);
    chk_all("R6");
    wr(3'd4, 16'h8000);
    chk_all("R7");

    // R8: ack clearing pending coincides with a new failing erase
    wr(3'd4, 16'h0000);
    cyc(1'b0, 3'd0, 16'h0, 3'b001, 3'b001);
    cyc(1'b1, 3'd4, 16'h0000, 3'b100, 3'b100);
    chk_all("R8");
    cyc(1'b1, 3'd4, 16'h7FFF, 3'b010, 3'b000);
    chk_all("R8");

    // R9 polarity with pending both ways
    wr(3'd4, 16'h0000);
    wr(3'd1, 16'h0000);
    chk_all("R9");
    cyc(1'b0, 3'd0, 16'h0, 3'b010, 3'b0);
    chk_all("R9");
    wr(3'd1, 16'h00FF);
    chk_all("R10");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule